// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Mirror

This block keeps the interrupt state of a disk controller with two channels. Each channel has one pending flag. The flag is held in two byte registers at once. The first is a legacy register that belongs to the channel. The second is a shared mode register that carries both channels' flags. The two copies stay equal no matter which one software clears. The mode register also holds one block bit per channel. A block bit masks that channel from the shared active-high interrupt line.

Each channel's drive logic supplies a level. A low-to-high change of that level marks the channel pending. A high-to-low change clears it. Software writes through a 32-bit configuration port. The port takes a dword index, four byte enables and a data word, and each enabled byte lane is handled as its own byte address. The pending flags clear when software writes a one to them. A separate side port lets a neighbouring block load the two block bits.

The block also provides a read-only channel-enable byte. The interrupt line is a register output that changes on the same clock edge as the state it is computed from.

Top module: `irq_mirror_top`

## Requirements
- R1: While reset is applied, and after it is released, every pending and block bit reads 0 and `irq_o` is low. All other bits of the three mirror registers read 0.
- R2: The channel-enable byte (address 0x51) reads 0x04. It reads 0x0C when `SECONDARY_EN` is 1. Configuration writes never change it.
- R3: A low-to-high change on `chan_level[c]` sets channel c pending. Channel 0 then shows bit 2 of address 0x50 and bit 2 of 0x71. Channel 1 shows bit 4 of 0x57 and bit 3 of 0x71. The change is visible one clock after the level is sampled high. Holding the level high does not set the flag again.
- R4: A high-to-low change on `chan_level[c]` clears both copies of channel c's flag one clock later.
- R5: A configuration write to byte 0x50 (lane 0 of dword index 0x14) with data bit 2 set clears channel 0 in both copies. The same write with bit 2 at 0 leaves the flag as it was.
- R6: A configuration write to byte 0x57 (lane 3 of dword index 0x15) with data bit 4 set clears channel 1 in both copies.
- R7: A configuration write to byte 0x71 (lane 1 of dword index 0x1C) clears channel 0 when data bit 2 is set and channel 1 when data bit 3 is set. Each channel is cleared independently, and both copies follow.
- R8: Configuration writes cannot set any bit, cannot change the block bits, and have no effect on lanes whose byte enable is 0.
- R9: A side-port write loads `side_blk[0]` into bit 4 and `side_blk[1]` into bit 5 of 0x71 on the next clock. The pending bits are left as they were.
- R10: `irq_o` equals (pending0 AND NOT block0) OR (pending1 AND NOT block1), using the register values of the same cycle.
- R11: When a channel's level rises in the same cycle as a write-one-to-clear of that channel, the flag ends up set.
- R12: One write with several byte enables applies every enabled lane. A full-dword write at index 0x14 clears channel 0 and leaves the channel-enable byte unchanged.
- R13: The legacy copy and the mode-register copy of each channel's flag are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chan_level | input | 2 | Interrupt level from each channel's drive logic |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Dword index of the configuration write (byte address divided by 4) |
| cfg_be | input | 4 | Byte enables, lane n is byte address 4*index+n |
| cfg_wdata | input | 32 | Write data, lane n in bits 8n+7..8n |
| side_wr_en | input | 1 | Side-port write strobe for the block bits |
| side_blk | input | 2 | New block bit values, index is the channel |
| leg0_rd | output | 8 | Read value of byte 0x50 |
| leg1_rd | output | 8 | Read value of byte 0x57 |
| mode_rd | output | 8 | Read value of byte 0x71 |
| chen_rd | output | 8 | Read value of byte 0x51 |
| irq_o | output | 1 | Combined interrupt line, active high |

## Verification
The mirror is exercised by clearing each channel from each of its two copies in turn. A flag that shows correctly in only one register therefore shows up as a mismatch. Clears are driven on the target lane, with the data bit at 0, with the byte enable off, and as a full four-lane write. These cases separate correct lane and bit decoding from mistakes in lane position or mask handling. Level edges are placed both alone and in the same cycle as a clear, which exposes the priority between the two. The block bits are swept through masked and unmasked combinations while both channels are pending, so the two terms of the interrupt equation are checked separately.

// File: rtl/irq_mirror_pkg.sv
package irq_mirror_pkg;

  localparam int NUM_CH = 2;

  // byte addresses in the configuration space
  localparam logic [7:0] OFS_LEG0 = 8'h50;
  localparam logic [7:0] OFS_CHEN = 8'h51;
  localparam logic [7:0] OFS_LEG1 = 8'h57;
  localparam logic [7:0] OFS_MODE = 8'h71;

  // field positions inside the shared mode byte
  localparam int MODE_PEND_LSB = 2;
  localparam int MODE_BLK_LSB  = 4;

  // channel-enable reset pattern
  localparam logic [7:0] CHEN_PRI = 8'h04;
  localparam logic [7:0] CHEN_SEC = 8'h08;

  function automatic logic [7:0] leg_ofs(input int ch);
    return (ch == 0) ? OFS_LEG0 : OFS_LEG1;
  endfunction

  function automatic int leg_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction

endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_mirror_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES),
  localparam int IDX_W  = ADDR_W - LANE_W
) (
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     dw_addr,
  input  logic [LANES-1:0]     be,
  input  logic [8*LANES-1:0]   wdata,
  output logic [NUM_CH-1:0]    leg_touch,
  output logic [NUM_CH-1:0]    leg_clr,
  output logic                 mode_touch,
  output logic [NUM_CH-1:0]    mode_clr
);

  logic [NUM_CH-1:0] lane_leg_touch [LANES];
  logic [NUM_CH-1:0] lane_leg_clr   [LANES];
  logic [NUM_CH-1:0] lane_mode_clr  [LANES];
  logic [LANES-1:0]  lane_mode_touch;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [ADDR_W-1:0] byte_addr;
    logic [7:0]        lane_data;
    logic              lane_act;

    assign byte_addr = {dw_addr, LANE_W'(ln)};
    assign lane_data = wdata[8*ln +: 8];
    assign lane_act  = wr_en & be[ln];
    assign lane_mode_touch[ln] = lane_act && (byte_addr == ADDR_W'(OFS_MODE));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign lane_leg_touch[ln][ch] = lane_act && (byte_addr == ADDR_W'(leg_ofs(ch)));
      assign lane_leg_clr[ln][ch]   = lane_leg_touch[ln][ch] &&
                                      (|(lane_data & (8'd1 << leg_bit(ch))));
      assign lane_mode_clr[ln][ch]  = lane_mode_touch[ln] &&
                                      (|(lane_data & (8'd1 << (MODE_PEND_LSB + ch))));
    end
  end

  always_comb begin
    leg_touch  = '0;
    leg_clr    = '0;
    mode_clr   = '0;
    mode_touch = |lane_mode_touch;
    for (int ln = 0; ln < LANES; ln++) begin
      leg_touch = leg_touch | lane_leg_touch[ln];
      leg_clr   = leg_clr   | lane_leg_clr[ln];
      mode_clr  = mode_clr  | lane_mode_clr[ln];
    end
  end

endmodule

// File: rtl/irq_chan_pending.sv
module irq_chan_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic leg_touch,
  input  logic leg_clr,
  input  logic mode_touch,
  input  logic mode_clr,
  output logic leg_q,
  output logic mode_q,
  output logic pend_n
);

  logic prev_q;
  logic rise, fall, upd;
  logic leg_d, mode_d;

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
  assign upd  = leg_touch | mode_touch | rise | fall;

  // write side first, then sync, then the level event (level wins)
  always_comb begin
    leg_d  = leg_q;
    mode_d = mode_q;
    if (leg_touch) begin
      if (leg_clr) leg_d = 1'b0;
      mode_d = leg_d;
    end
    if (mode_touch) begin
      if (mode_clr) mode_d = 1'b0;
      leg_d = mode_d;
    end
    if (rise) begin
      leg_d  = 1'b1;
      mode_d = 1'b1;
    end else if (fall) begin
      leg_d  = 1'b0;
      mode_d = 1'b0;
    end
    pend_n = upd ? mode_d : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      leg_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (upd) begin
        leg_q  <= leg_d;
        mode_q <= mode_d;
      end
    end
  end

  AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    leg_q == mode_q); // R13
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (level && !prev_q) |=> mode_q); // R3
  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && prev_q) |=> !mode_q); // R4
  AST_CLR_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((leg_clr || mode_clr) && (level == prev_q)) |=> !mode_q); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!leg_clr && !mode_clr && (level == prev_q)) |=> $stable(mode_q)); // R8

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend_n,
  input  logic [NUM_CH-1:0] blk_n,
  output logic              irq_q
);

  logic irq_d;

  always_comb irq_d = |(pend_n & ~blk_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/irq_mirror_top.sv
module irq_mirror_top
  import irq_mirror_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int LANES        = 4,
  parameter bit SECONDARY_EN = 1'b0,
  localparam int LANE_W = $clog2(LANES),
  localparam int IDX_W  = ADDR_W - LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   chan_level,
  input  logic                cfg_wr_en,
  input  logic [IDX_W-1:0]    cfg_dw_addr,
  input  logic [LANES-1:0]    cfg_be,
  input  logic [8*LANES-1:0]  cfg_wdata,
  input  logic                side_wr_en,
  input  logic [NUM_CH-1:0]   side_blk,
  output logic [7:0]          leg0_rd,
  output logic [7:0]          leg1_rd,
  output logic [7:0]          mode_rd,
  output logic [7:0]          chen_rd,
  output logic                irq_o
);

  localparam logic [7:0] CHEN_RST = CHEN_PRI | (SECONDARY_EN ? CHEN_SEC : 8'h00);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // configuration lane decode
  logic [NUM_CH-1:0] leg_touch, leg_clr, mode_clr;
  logic              cfg_mode_touch;

  irq_cfg_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .wr_en      (cfg_wr_en),
    .dw_addr    (cfg_dw_addr),
    .be         (cfg_be),
    .wdata      (cfg_wdata),
    .leg_touch  (leg_touch),
    .leg_clr    (leg_clr),
    .mode_touch (cfg_mode_touch),
    .mode_clr   (mode_clr)
  );

  // block bits, loaded only from the side port
  logic [NUM_CH-1:0] blk_q, blk_d;

  always_comb blk_d = side_wr_en ? side_blk : blk_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)      blk_q <= '0;
    else if (side_wr_en) blk_q <= blk_d;
  end

  // channel-enable byte, fixed after reset
  logic [7:0] chen_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) chen_q <= CHEN_RST;
    else            chen_q <= chen_q;
  end

  // per-channel pending copies
  logic [NUM_CH-1:0] leg_q, mode_q, pend_n;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    irq_chan_pending u_pend (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .level      (chan_level[ch]),
      .leg_touch  (leg_touch[ch]),
      .leg_clr    (leg_clr[ch]),
      .mode_touch (cfg_mode_touch | side_wr_en),
      .mode_clr   (mode_clr[ch]),
      .leg_q      (leg_q[ch]),
      .mode_q     (mode_q[ch]),
      .pend_n     (pend_n[ch])
    );
  end

  irq_combine #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pend_n (pend_n),
    .blk_n  (blk_d),
    .irq_q  (irq_o)
  );

  // read-back assembly
  always_comb begin
    leg0_rd = 8'(leg_q[0]) << leg_bit(0);
    leg1_rd = 8'(leg_q[1]) << leg_bit(1);
    mode_rd = (8'(mode_q) << MODE_PEND_LSB) | (8'(blk_q) << MODE_BLK_LSB);
    chen_rd = chen_q;
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o == |(mode_q & ~blk_q)); // R10
  AST_BLK_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_int_n)
    !side_wr_en |=> $stable(blk_q)); // R8
  AST_BLK_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    side_wr_en |=> (blk_q == $past(side_blk))); // R9
  AST_CHEN_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> $stable(chen_q)); // R2

endmodule

// File: tb/irq_mirror_top_test.sv
module irq_mirror_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  chan_level = 2'b00;
  logic        cfg_wr_en = 1'b0;
  logic [5:0]  cfg_dw_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        side_wr_en = 1'b0;
  logic [1:0]  side_blk = '0;
  logic [7:0]  leg0_rd, leg1_rd, mode_rd, chen_rd;
  logic        irq_o;
  logic [7:0]  leg0_b, leg1_b, mode_b, chen_b;
  logic        irq_b;

  always #5 clk = ~clk;

  irq_mirror_top uut (
    .clk(clk), .rst_n(rst_n), .chan_level(chan_level),
    .cfg_wr_en(cfg_wr_en), .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .side_wr_en(side_wr_en), .side_blk(side_blk),
    .leg0_rd(leg0_rd), .leg1_rd(leg1_rd), .mode_rd(mode_rd),
    .chen_rd(chen_rd), .irq_o(irq_o)
  );

  irq_mirror_top #(.SECONDARY_EN(1'b1)) uut_sec (
    .clk(clk), .rst_n(rst_n), .chan_level(2'b00),
    .cfg_wr_en(1'b0), .cfg_dw_addr(6'd0), .cfg_be(4'd0),
    .cfg_wdata(32'd0), .side_wr_en(1'b0), .side_blk(2'b00),
    .leg0_rd(leg0_b), .leg1_rd(leg1_b), .mode_rd(mode_b),
    .chen_rd(chen_b), .irq_o(irq_b)
  );

  typedef struct {
    logic [7:0] l0, l1, md, ch;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // reference state
  logic [1:0] m_pend = 2'b00, m_blk = 2'b00, m_prev = 2'b00;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(input string tag, input logic [1:0] lvl,
                      input logic wr, input logic [5:0] idx, input logic [3:0] be,
                      input logic [31:0] d, input logic sw, input logic [1:0] sb);
    logic [1:0] clr;
    exp_t e;
    @(negedge clk);
    chan_level = lvl; cfg_wr_en = wr; cfg_dw_addr = idx; cfg_be = be;
    cfg_wdata = d; side_wr_en = sw; side_blk = sb;
    clr = 2'b00;
    if (wr) begin
      for (int ln = 0; ln < 4; ln++) begin
        logic [7:0] ba, bd;
        ba = {idx, 2'(ln)};
        bd = d[8*ln +: 8];
        if (be[ln]) begin
          if (ba == 8'h50 && bd[2]) clr[0] = 1'b1;
          if (ba == 8'h57 && bd[4]) clr[1] = 1'b1;
          if (ba == 8'h71) begin
            if (bd[2]) clr[0] = 1'b1;
            if (bd[3]) clr[1] = 1'b1;
          end
        end
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (clr[c]) m_pend[c] = 1'b0;
      if (lvl[c] && !m_prev[c]) m_pend[c] = 1'b1;
      if (!lvl[c] && m_prev[c]) m_pend[c] = 1'b0;
    end
    m_prev = lvl;
    if (sw) m_blk = sb;
    e.l0  = {5'd0, m_pend[0], 2'd0};
    e.l1  = {3'd0, m_pend[1], 4'd0};
    e.md  = {2'd0, m_blk, m_pend, 2'd0};
    e.ch  = 8'h04;
    e.irq = |(m_pend & ~m_blk);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, m_prev, 1'b0, 6'd0, 4'd0, 32'd0, 1'b0, 2'b00);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "leg0", 32'(leg0_rd), 32'(e.l0));
        chk(e.tag, "leg1", 32'(leg1_rd), 32'(e.l1));
        chk(e.tag, "mode", 32'(mode_rd), 32'(e.md));
        chk(e.tag, "chen", 32'(chen_rd), 32'(e.ch));
        chk(e.tag, "irq",  32'(irq_o),   32'(e.irq));
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #23;
    // R1: values while reset is held
    chk("R1", "leg0 in reset", 32'(leg0_rd), 32'h0);
    chk("R1", "mode in reset", 32'(mode_rd), 32'h0);
    chk("R1", "irq in reset",  32'(irq_o),   32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle("R1");
    // R2: channel-enable byte for both parameter values
    chk("R2", "chen primary", 32'(chen_rd), 32'h04);
    chk("R2", "chen secondary", 32'(chen_b), 32'h0C);
    // R3: rising levels set both copies
    step("R3", 2'b01, 0, 6'd0, 4'd0, 32'd0, 0, 2'b00);
    step("R3", 2'b11, 0, 6'd0, 4'd0, 32'd0, 0, 2'b00);
    idle("R3");
    // R5: data bit clear leaves flag, set clears via 0x50
    step("R5", 2'b11, 1, 6'h14, 4'b0001, 32'h0000_00FB, 0, 2'b00);
    step("R5", 2'b11, 1, 6'h14, 4'b0001, 32'h0000_0004, 0, 2'b00);
    idle("R5");
    // R6: clear channel 1 via 0x57
    step("R6", 2'b11, 1, 6'h15, 4'b1000, 32'h1000_0000, 0, 2'b00);
    // R4: falls, then R3 rises again
    step("R4", 2'b00, 0, 6'd0, 4'd0, 32'd0, 0, 2'b00);
    step("R3", 2'b11, 0, 6'd0, 4'd0, 32'd0, 0, 2'b00);
    // R9 / R10: block masking combinations
    step("R9", 2'b11, 0, 6'd0, 4'd0, 32'd0, 1, 2'b11);
    step("R10", 2'b11, 0, 6'd0, 4'd0, 32'd0, 1, 2'b01);
    step("R10", 2'b11, 0, 6'd0, 4'd0, 32'd0, 1, 2'b10);
    // R8: mode byte writes with lane off change nothing
    step("R8", 2'b11, 1, 6'h1C, 4'b1101, 32'hFFFF_FFFF, 0, 2'b00);
    // R7: clear only channel 0 via 0x71, block bits untouched (R8)
    step("R7", 2'b11, 1, 6'h1C, 4'b0010, 32'h0000_0400, 0, 2'b00);
    // R7: both channels via 0x71 in one write
    step("R4", 2'b01, 0, 6'd0, 4'd0, 32'd0, 0, 2'b00);
    step("R3", 2'b11, 0, 6'd0, 4'd0, 32'd0, 0, 2'b00);
    step("R7", 2'b11, 1, 6'h1C, 4'b0010, 32'hFFFF_FFFF, 0, 2'b00);
    step("R8", 2'b11, 0, 6'd0, 4'd0, 32'd0, 1, 2'b00);
    // R11: rise in the same cycle as a clear of that channel
    step("R4", 2'b00, 0, 6'd0, 4'd0, 32'd0, 0, 2'b00);
    step("R11", 2'b01, 1, 6'h14, 4'b0001, 32'h0000_0004, 0, 2'b00);
    step("R11", 2'b11, 1, 6'h15, 4'b1000, 32'h1000_0000, 0, 2'b00);
    idle("R13");
    // R12: full-dword write at 0x50 clears channel 0, enable byte kept
    step("R12", 2'b11, 1, 6'h14, 4'b1111, 32'hFFFF_FFFF, 0, 2'b00);
    // R4: channel 1 falls
    step("R4", 2'b01, 0, 6'd0, 4'd0, 32'd0, 0, 2'b00);
    idle("R13");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule